// File: doc/BRIEF.md
# Vectored Interrupt Controller with Indexed Source Registers

This block gathers interrupt requests from a parameterised set of peripheral sources (32 by default) and tells a processor core which service routine to run. Each source owns a handler address, a 3-bit priority, a sensitivity mode (level or rising edge) and an enable bit. Software does not address these per-source fields directly. It first writes a source number into an index register, and the following accesses to the vector and configuration registers then act on that source alone.

The controller drives an active-low request line to the core while an enabled pending source outranks whatever is already in service. The core's read of the acknowledge register is the acknowledge itself. It returns the winner's handler address, records the winner's priority on a small in-service stack, and clears the winner's latched edge. A write to the end-of-interrupt register pops that stack and brings back the level that was active before. An acknowledge read with nothing to take returns a programmable spurious value and changes nothing.

The register bus is a flat word-addressed port with separate read and write strobes. Read data is combinational in the strobe cycle, and side effects land on the clock edge that ends the cycle.

Top module: `vic_top`

## Requirements
- R1: After reset, irq_n is 1, the index register (address 0) reads 0, the enable mask reads 0, and the spurious register (address 7) reads 0.
- R2: Address 0 holds the source index. Address 1 (handler address) and address 2 (configuration: bits 2:0 priority, bit 3 set means rising edge, clear means level) read and write the fields of the indexed source only.
- R3: A write to address 3 sets the enable bits that are 1 in the data. A write to address 4 clears the enable bits that are 1 in the data. A read of either address returns the enable mask, with bit n standing for source n.
- R4: A source whose enable bit is 0 never drives irq_n low, whatever its input does.
- R5: A level source is pending exactly while its input is 1. irq_n returns to 1 when the input drops, with no acknowledge.
- R6: An edge source latches pending on a 0-to-1 input transition, and stays pending after the input falls.
- R7: Among enabled pending sources, the highest priority wins. On equal priority, the lowest source index wins.
- R8: A read of address 5 while irq_n is 0 returns the winner's handler address and records the winner as in service. irq_n then stays 1 while no pending source has a strictly higher priority.
- R9: The acknowledge clears the latched pending of an edge winner.
- R10: While a source is in service, a pending source of strictly higher priority drives irq_n low again, up to NEST_DEPTH levels. With all levels in use, irq_n stays 1.
- R11: A write of any value to address 6 drops the most recent in-service level, so a source that outranks the level now exposed (or any source, once none is left) drives irq_n low again.
- R12: A read of address 5 while irq_n is 1 returns the value at address 7 and changes neither the in-service state nor any pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NUM_SRC | Interrupt inputs from the peripherals |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 5 acknowledges) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq_n | output | 1 | Active-low interrupt request to the core |

## Verification
The embedded assertions check on every cycle that irq_n is never low without an enabled pending source, and that a taken acknowledge grows the in-service stack by exactly one. They also check that an end-of-interrupt shrinks the stack by one, that a spurious acknowledge leaves it untouched, that the edge-clear strobe is one-hot and really empties its latch, and that no entry is pushed onto a full stack. The bench scenarios are what show the arbitration order, namely the priority win and the lowest-index tie break. They also show that the returned handler addresses match the indexed programming, and that end-of-interrupt makes masked lower-priority sources visible again.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int PRIO_W   = 3;
  localparam int EDGE_BIT = PRIO_W;

  localparam logic [ADDR_W-1:0] RA_INDEX = 3'd0;
  localparam logic [ADDR_W-1:0] RA_VEC   = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CFG   = 3'd2;
  localparam logic [ADDR_W-1:0] RA_ENSET = 3'd3;
  localparam logic [ADDR_W-1:0] RA_ENCLR = 3'd4;
  localparam logic [ADDR_W-1:0] RA_ACK   = 3'd5;
  localparam logic [ADDR_W-1:0] RA_EOI   = 3'd6;
  localparam logic [ADDR_W-1:0] RA_SPUR  = 3'd7;
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = 32,
  parameter int SEL_W   = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SRC-1:0]                src_req,
  input  logic [SEL_W-1:0]                  sel_idx,
  input  logic                              vec_we,
  input  logic                              cfg_we,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic                              en_set_we,
  input  logic                              en_clr_we,
  input  logic [NUM_SRC-1:0]                clr_pend,
  output logic [NUM_SRC-1:0][VEC_W-1:0]     vec_all,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_all,
  output logic [NUM_SRC-1:0]                edge_all,
  output logic [NUM_SRC-1:0]                enable,
  output logic [NUM_SRC-1:0]                pend
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hit;
    logic req_q;
    logic edge_hold;
    logic rise;

    assign hit  = (sel_idx == SEL_W'(i));
    assign rise = src_req[i] & ~req_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_all[i]  <= '0;
        prio_all[i] <= '0;
        edge_all[i] <= 1'b0;
        enable[i]   <= 1'b0;
        req_q       <= 1'b0;
        edge_hold   <= 1'b0;
      end else begin
        req_q <= src_req[i];
        if (vec_we && hit) vec_all[i] <= wdata[VEC_W-1:0];
        if (cfg_we && hit) begin
          prio_all[i] <= wdata[PRIO_W-1:0];
          edge_all[i] <= wdata[EDGE_BIT];
        end
        if (en_set_we && wdata[i]) enable[i] <= 1'b1;
        else if (en_clr_we && wdata[i]) enable[i] <= 1'b0;
        if (rise) edge_hold <= 1'b1;
        else if (clr_pend[i]) edge_hold <= 1'b0;
      end
    end

    assign pend[i] = edge_all[i] ? edge_hold : src_req[i];

    // R9
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pend[i] && edge_all[i] && !rise) |=> !edge_hold);
  end

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0]             cand,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_all,
  output logic                           win_valid,
  output logic [IDX_W-1:0]               win_idx,
  output logic [PRIO_W-1:0]              win_prio
);

  localparam int RES_W = 1 + PRIO_W + IDX_W;

  // Scan from the top index down; ">=" lets a lower index take a tie.
  function automatic logic [RES_W-1:0] pick(
    input logic [NUM_SRC-1:0]             c,
    input logic [NUM_SRC-1:0][PRIO_W-1:0] p
  );
    logic              found;
    logic [PRIO_W-1:0] bp;
    logic [IDX_W-1:0]  bi;
    found = 1'b0;
    bp    = '0;
    bi    = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (c[i] && (!found || p[i] >= bp)) begin
        found = 1'b1;
        bp    = p[i];
        bi    = IDX_W'(i);
      end
    end
    return {found, bp, bi};
  endfunction

  always_comb begin
    {win_valid, win_prio, win_idx} = pick(cand, prio_all);
  end

endmodule

// File: rtl/vic_isr_stack.sv
module vic_isr_stack
  import vic_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [CNT_W-1:0]  depth,
  output logic [PRIO_W-1:0] top_prio,
  output logic              empty,
  output logic              full
);

  logic [PRIO_W-1:0] lvl [DEPTH];

  assign empty = (depth == '0);
  assign full  = (depth == CNT_W'(DEPTH));

  always_comb begin
    top_prio = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (depth == CNT_W'(i + 1)) top_prio = lvl[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) lvl[i] <= '0;
    end else begin
      if (push && !full) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (depth == CNT_W'(i)) lvl[i] <= push_prio;
        end
        depth <= depth + 1'b1;
      end else if (pop && !empty) begin
        depth <= depth - 1'b1;
      end
    end
  end

  // R10
  push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> depth == $past(depth) + 1'b1);

  // R11
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> depth == $past(depth) - 1'b1);

  // R10
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC    = 32,
  parameter int VEC_W      = 32,
  parameter int NEST_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [2:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_n
);

  localparam int SEL_W = $clog2(NUM_SRC);
  localparam int CNT_W = $clog2(NEST_DEPTH + 1);

  logic [SEL_W-1:0]               sel_idx;
  logic [VEC_W-1:0]               spur_vec;
  logic [NUM_SRC-1:0][VEC_W-1:0]  vec_all;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_all;
  logic [NUM_SRC-1:0]             edge_all;
  logic [NUM_SRC-1:0]             enable;
  logic [NUM_SRC-1:0]             pend;
  logic [NUM_SRC-1:0]             cand;
  logic [NUM_SRC-1:0]             clr_pend;
  logic                           win_valid;
  logic [SEL_W-1:0]               win_idx;
  logic [PRIO_W-1:0]              win_prio;
  logic [CNT_W-1:0]               depth;
  logic [PRIO_W-1:0]              top_prio;
  logic                           stk_empty;
  logic                           stk_full;

  // Named events for the assertions.
  logic wr_index, wr_vec, wr_cfg, wr_enset, wr_enclr, wr_eoi, wr_spur;
  logic ack_rd, take_ok, ack_take, ack_spur;

  assign wr_index = bus_wr && (bus_addr == RA_INDEX);
  assign wr_vec   = bus_wr && (bus_addr == RA_VEC);
  assign wr_cfg   = bus_wr && (bus_addr == RA_CFG);
  assign wr_enset = bus_wr && (bus_addr == RA_ENSET);
  assign wr_enclr = bus_wr && (bus_addr == RA_ENCLR);
  assign wr_eoi   = bus_wr && (bus_addr == RA_EOI);
  assign wr_spur  = bus_wr && (bus_addr == RA_SPUR);
  assign ack_rd   = bus_rd && (bus_addr == RA_ACK);

  function automatic logic outranks(
    input logic              valid,
    input logic [PRIO_W-1:0] cand_prio,
    input logic              none_active,
    input logic              no_room,
    input logic [PRIO_W-1:0] active_prio
  );
    return valid && !no_room && (none_active || cand_prio > active_prio);
  endfunction

  assign cand     = pend & enable;
  assign take_ok  = outranks(win_valid, win_prio, stk_empty, stk_full, top_prio);
  assign ack_take = ack_rd && take_ok;
  assign ack_spur = ack_rd && !take_ok;
  assign clr_pend = ack_take ? (NUM_SRC'(1) << win_idx) : '0;
  assign irq_n    = !take_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx  <= '0;
      spur_vec <= '0;
    end else begin
      if (wr_index && bus_wdata < NUM_SRC) sel_idx <= bus_wdata[SEL_W-1:0];
      if (wr_spur) spur_vec <= bus_wdata[VEC_W-1:0];
    end
  end

  vic_src_bank #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .SEL_W(SEL_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .sel_idx   (sel_idx),
    .vec_we    (wr_vec),
    .cfg_we    (wr_cfg),
    .wdata     (bus_wdata),
    .en_set_we (wr_enset),
    .en_clr_we (wr_enclr),
    .clr_pend  (clr_pend),
    .vec_all   (vec_all),
    .prio_all  (prio_all),
    .edge_all  (edge_all),
    .enable    (enable),
    .pend      (pend)
  );

  vic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(SEL_W)) u_arb (
    .cand      (cand),
    .prio_all  (prio_all),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  vic_isr_stack #(.DEPTH(NEST_DEPTH), .CNT_W(CNT_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_take),
    .push_prio (win_prio),
    .pop       (wr_eoi),
    .depth     (depth),
    .top_prio  (top_prio),
    .empty     (stk_empty),
    .full      (stk_full)
  );

  always_comb begin
    unique case (bus_addr)
      RA_INDEX:           bus_rdata = 32'(sel_idx);
      RA_VEC:             bus_rdata = 32'(vec_all[sel_idx]);
      RA_CFG:             bus_rdata = 32'({edge_all[sel_idx], prio_all[sel_idx]});
      RA_ENSET, RA_ENCLR: bus_rdata = 32'(enable);
      RA_ACK:             bus_rdata = take_ok ? 32'(vec_all[win_idx]) : 32'(spur_vec);
      RA_SPUR:            bus_rdata = 32'(spur_vec);
      default:            bus_rdata = '0;
    endcase
  end

  // R4
  irq_enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (pend & enable) != '0);

  // R12
  spur_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_spur && !wr_eoi) |=> $stable(depth));

  // R9
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_pend));

  // R8
  ack_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> !stk_empty);

endmodule

// File: tb/test_vic_top.sv
module test_vic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vic_top i_vic_top (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  // Entry: {req[3:0], kind[1:0] (1 write, 2 read and check), addr[2:0], data[31:0]}
  localparam int NV = 19;
  localparam logic [40:0] VTAB [NV] = '{
    {4'd2, 2'd1, 3'd0, 32'd5},          // R2 index 5
    {4'd2, 2'd1, 3'd1, 32'h1000_0500},
    {4'd2, 2'd1, 3'd2, 32'h3},          // level, priority 3
    {4'd2, 2'd1, 3'd0, 32'd9},
    {4'd2, 2'd1, 3'd1, 32'h900},
    {4'd2, 2'd1, 3'd2, 32'hE},          // edge, priority 6
    {4'd2, 2'd1, 3'd0, 32'd2},
    {4'd2, 2'd1, 3'd1, 32'h200},
    {4'd2, 2'd1, 3'd2, 32'h3},
    {4'd12, 2'd1, 3'd7, 32'hDEAD},
    {4'd2, 2'd2, 3'd0, 32'd2},          // R2 readback
    {4'd2, 2'd2, 3'd1, 32'h200},
    {4'd2, 2'd1, 3'd0, 32'd9},
    {4'd2, 2'd2, 3'd2, 32'hE},
    {4'd3, 2'd1, 3'd3, 32'h224},        // R3 set 2,5,9
    {4'd3, 2'd2, 3'd3, 32'h224},
    {4'd3, 2'd1, 3'd4, 32'h200},        // R3 clear 9
    {4'd3, 2'd2, 3'd4, 32'h024},
    {4'd12, 2'd2, 3'd5, 32'hDEAD}       // R12 spurious with nothing pending
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int s);
    @(negedge clk); src_req[s] = 1'b1;
    @(negedge clk); src_req[s] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 irq_n in reset", 32'(irq_n), 32'd1);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 irq_n", 32'(irq_n), 32'd1);
    rd(3'd0, d); chk("R1 index", d, 32'd0);
    rd(3'd3, d); chk("R1 enable mask", d, 32'd0);
    rd(3'd7, d); chk("R1 spurious", d, 32'd0);

    for (int k = 0; k < NV; k++) begin
      if (VTAB[k][36:35] == 2'd1) wr(VTAB[k][34:32], VTAB[k][31:0]);
      else begin
        rd(VTAB[k][34:32], d);
        chk($sformatf("R%0d table entry %0d", VTAB[k][40:37], k), d, VTAB[k][31:0]);
      end
    end

    // R4: disabled edge source 9 and unconfigured source 7
    @(negedge clk); src_req[7] = 1'b1;
    pulse(9);
    chk("R4 disabled sources", 32'(irq_n), 32'd1);
    src_req[7] = 1'b0;

    // R5 / R7 tie between 2 and 5 at priority 3
    @(negedge clk); src_req[2] = 1'b1; src_req[5] = 1'b1;
    #2 chk("R5 level asserts", 32'(irq_n), 32'd0);
    rd(3'd5, d); chk("R7 tie to lowest index", d, 32'h200);
    #2 chk("R8 same level masked", 32'(irq_n), 32'd1);

    // R10: enabling 9 exposes its latched edge at priority 6
    wr(3'd3, 32'h200);
    #1 chk("R10 higher priority nests", 32'(irq_n), 32'd0);
    rd(3'd5, d); chk("R7 higher priority wins", d, 32'h900);
    #2 chk("R8 masked after ack", 32'(irq_n), 32'd1);

    wr(3'd6, 32'h0);
    #1 chk("R9 edge cleared, level 3 masks", 32'(irq_n), 32'd1);
    wr(3'd6, 32'h0);
    #1 chk("R11 eoi re-exposes", 32'(irq_n), 32'd0);
    rd(3'd5, d); chk("R8 vector after eoi", d, 32'h200);
    wr(3'd6, 32'h0);

    @(negedge clk); src_req[2] = 1'b0;
    #2 chk("R5 source 5 remains", 32'(irq_n), 32'd0);
    src_req[5] = 1'b0;
    #2 chk("R5 level drop releases", 32'(irq_n), 32'd1);

    // R6 edge latch
    pulse(9);
    chk("R6 edge held", 32'(irq_n), 32'd0);
    rd(3'd5, d); chk("R6 edge vector", d, 32'h900);
    wr(3'd6, 32'h0);
    #1 chk("R9 edge gone after ack", 32'(irq_n), 32'd1);

    // R12 spurious read leaves state
    rd(3'd5, d); chk("R12 spurious value", d, 32'hDEAD);
    @(negedge clk); src_req[5] = 1'b1;
    #2 chk("R12 no level left behind", 32'(irq_n), 32'd0);
    rd(3'd5, d); chk("R12 real ack after", d, 32'h1000_0500);

    // R10 full stack: 5 (p3) in service, then 9 (p6)
    pulse(9);
    rd(3'd5, d); chk("R10 second level", d, 32'h900);
    wr(3'd0, 32'd2); wr(3'd2, 32'h7);
    @(negedge clk); src_req[2] = 1'b1;
    #2 chk("R10 full stack holds", 32'(irq_n), 32'd1);
    wr(3'd6, 32'h0);
    #1 chk("R11 p7 outranks level 3", 32'(irq_n), 32'd0);
    rd(3'd5, d); chk("R7 priority 7 winner", d, 32'h200);
    wr(3'd6, 32'h0); wr(3'd6, 32'h0);
    src_req = '0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule